// File: doc/BRIEF.md
# Windowed Page Mapper with Access Wait Timing

The block sits between a 16-bit CPU and a 21-bit physical memory bus. The logical space is split into eight equal windows of 8 KB. The top three address bits pick one of eight 8-bit page registers, and the value held there becomes the upper part of the physical address. Each access also gets a wait count. The count comes from the class of the physical page (fast static pages or slow dynamic pages), from the active speed preset, and from a video-region flag. The block holds the CPU ready line low for exactly that many cycles.

Software rewrites the page registers through a small write window in the logical space. A speed-preset load replaces the pages of the two timing-critical windows (the lowest window and the one at 8000-9FFF) with values from a fixed table, and selects whether one extra wait is added. A ROM-redirect input swaps the window at 4000-5FFF onto the peripheral page. A small internal fast RAM range never reaches the external bus and never waits, whatever page the top window holds.

Top module: `win_mapper`

## Requirements
- R1: The physical address equals {page, cpu_addr[12:0]}, where page is the register picked by cpu_addr[15:13].
- R2: After reset, windows 0 to 7 hold pages EC, ED, 07, 34, EE, EF, 03, 53 (hex), speed preset 5 is active and ready is high.
- R3: An accepted write with cpu_addr[15:3] equal to CFG_BASE[15:3] (default F800) stores cpu_wdata into page register cpu_addr[2:0]. The write raises no mem_sel and takes zero waits.
- R4: A preset_load pulse with preset_sel 1, 2, 3, 4 or 5 loads window 0 with EC, 33, EC, 33, EC and window 4 with 34, 34, 34, EE, EE. Codes 0, 6 and 7 change nothing.
- R5: When a preset load and a configuration write to window 0 or 4 happen in the same cycle, the preset value is the one stored.
- R6: While rom_redirect is high, window 2 maps to page BA instead of its register.
- R7: mem_fast is high exactly when the current page is EC, ED, EE or EF. mem_sel is high during a strobe that targets neither the internal fast range nor the configuration window.
- R8: After an accepted strobe, ready stays low for the number of cycles given by three summed terms: one if the page is slow, one if preset 1 is active, and one if video_hit is high.
- R9: Preset 1 adds one wait to every external access. Presets 2 to 5 add none.
- R10: Accesses to F000-F0FF raise no mem_sel and leave ready high, whatever page window 7 holds.
- R11: A strobe that arrives while ready is low is ignored. It does not restart the wait count, and a configuration write made then does not change any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data (used by page register writes) |
| video_hit | input | 1 | Access targets the video region (one extra wait) |
| rom_redirect | input | 1 | Map window 2 onto the peripheral page |
| preset_load | input | 1 | Load the speed preset given by preset_sel |
| preset_sel | input | 3 | Speed preset number 1 to 5 |
| ready | output | 1 | High when the CPU may proceed |
| mem_addr | output | 21 | Physical address |
| mem_sel | output | 1 | External memory select |
| mem_fast | output | 1 | Current page is a fast zero-wait page |

## Verification
The bench builds the block with its default parameters. These are the eight windows of 8-bit pages, the configuration window at F800, the internal range F000-F0FF, window 2 as the redirect window, and video waits enabled. With video waits enabled, the largest sum of three waits (slow page, preset 1 and video) can be reached. The internal range, the configuration window and window 7 all sit near each other at the top of the space, so the boundary reads at F0FF and F100 show where the bypass stops and mapped access begins.

// File: rtl/win_mapper_pkg.sv
package win_mapper_pkg;

   localparam int unsigned SEL_W   = 3;
   localparam int unsigned WAIT_W  = 2;

   // Power-up page of each window.
   function automatic logic [7:0] boot_page(input int unsigned idx);
      case (idx)
         0:       return 8'hEC;
         1:       return 8'hED;
         2:       return 8'h07;
         3:       return 8'h34;
         4:       return 8'hEE;
         5:       return 8'hEF;
         6:       return 8'h03;
         default: return 8'h53;
      endcase
   endfunction

   function automatic logic preset_ok(input logic [SEL_W-1:0] s);
      return (s >= 3'd1) && (s <= 3'd5);
   endfunction

   // Page loaded into the lowest window by a preset.
   function automatic logic [7:0] preset_low(input logic [SEL_W-1:0] s);
      return (s == 3'd2 || s == 3'd4) ? 8'h33 : 8'hEC;
   endfunction

   // Page loaded into the middle window by a preset.
   function automatic logic [7:0] preset_mid(input logic [SEL_W-1:0] s);
      return (s == 3'd4 || s == 3'd5) ? 8'hEE : 8'h34;
   endfunction

   // Static zero-wait pages EC..EF share their upper six bits.
   function automatic logic page_is_fast(input logic [7:0] p);
      return p[7:2] == 6'h3B;
   endfunction

endpackage

// File: rtl/wm_page_file.sv
module wm_page_file
   import win_mapper_pkg::*;
#(
   parameter int unsigned WIN_CNT = 8,
   parameter int unsigned PAGE_W  = 8,
   localparam int unsigned IDX_W  = $clog2(WIN_CNT),
   localparam int unsigned LOW_WIN = 0,
   localparam int unsigned MID_WIN = WIN_CNT / 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [PAGE_W-1:0]           wr_data,
   input  logic                        load_en,
   input  logic [SEL_W-1:0]            load_sel,
   output logic [WIN_CNT*PAGE_W-1:0]   pages,
   output logic                        slow_speed
);

   logic [PAGE_W-1:0] pg [WIN_CNT];
   logic [SEL_W-1:0]  speed_q;
   logic              load_ok;

   assign load_ok = load_en && preset_ok(load_sel);

   for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pg[w] <= PAGE_W'(boot_page(w));
         end else if (load_ok && (w == LOW_WIN)) begin
            pg[w] <= PAGE_W'(preset_low(load_sel));
         end else if (load_ok && (w == MID_WIN)) begin
            pg[w] <= PAGE_W'(preset_mid(load_sel));
         end else if (wr_en && (wr_idx == IDX_W'(w))) begin
            pg[w] <= wr_data;
         end
      end
      assign pages[w*PAGE_W +: PAGE_W] = pg[w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       speed_q <= SEL_W'(5);
      else if (load_ok) speed_q <= load_sel;
   end

   assign slow_speed = (speed_q == SEL_W'(1));

   AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> (pg[LOW_WIN] == PAGE_W'(preset_low($past(load_sel))))); // R5

   AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> (pg[MID_WIN] == PAGE_W'(preset_mid($past(load_sel))))); // R4

endmodule

// File: rtl/wm_xlate.sv
module wm_xlate
   import win_mapper_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned WIN_CNT = 8,
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned ROM_WIN = 2,
   parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hBA,
   localparam int unsigned IDX_W  = $clog2(WIN_CNT),
   localparam int unsigned OFS_W  = ADDR_W - IDX_W,
   localparam int unsigned PA_W   = OFS_W + PAGE_W
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        rom_en,
   input  logic [WIN_CNT*PAGE_W-1:0]   pages,
   output logic [PA_W-1:0]             phys,
   output logic                        fast
);

   logic [IDX_W-1:0]  idx;
   logic [PAGE_W-1:0] page;

   assign idx = addr[ADDR_W-1 -: IDX_W];

   always_comb begin
      page = pages[idx*PAGE_W +: PAGE_W];
      if (rom_en && (idx == IDX_W'(ROM_WIN))) page = ROM_PAGE;
   end

   assign phys = {page, addr[OFS_W-1:0]};
   assign fast = page_is_fast(8'(page));

endmodule

// File: rtl/wm_wait_ctr.sv
module wm_wait_ctr
   import win_mapper_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [WAIT_W-1:0] waits,
   output logic              ready
);

   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (cnt != '0)         cnt <= cnt - WAIT_W'(1);
      else if (strobe)            cnt <= waits;
   end

   assign ready = (cnt == '0);

   AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(strobe)); // R8

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && strobe) |=> (cnt == $past(cnt) - WAIT_W'(1))); // R11

endmodule

// File: rtl/win_mapper.sv
module win_mapper
   import win_mapper_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WIN_CNT   = 8,
   parameter int unsigned PAGE_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_BASE  = 16'hF800,
   parameter logic [ADDR_W-1:0] FAST_BASE = 16'hF000,
   parameter int unsigned FAST_SIZE = 256,
   parameter int unsigned ROM_WIN   = 2,
   parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hBA,
   parameter bit          VIDEO_WAITS = 1'b1,
   localparam int unsigned IDX_W    = $clog2(WIN_CNT),
   localparam int unsigned PA_W     = ADDR_W - IDX_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [PAGE_W-1:0] cpu_wdata,
   input  logic              video_hit,
   input  logic              rom_redirect,
   input  logic              preset_load,
   input  logic [SEL_W-1:0]  preset_sel,
   output logic              ready,
   output logic [PA_W-1:0]   mem_addr,
   output logic              mem_sel,
   output logic              mem_fast
);

   localparam logic [ADDR_W-1:0] FAST_LAST = ADDR_W'(FAST_BASE + FAST_SIZE - 1);

   if (PAGE_W != 8)              $error("page registers must be 8 bits wide");
   if (ADDR_W <= IDX_W)          $error("address too narrow for window count");
   if ((1 << IDX_W) != WIN_CNT)  $error("window count must be a power of two");
   if (ROM_WIN >= WIN_CNT)       $error("redirect window out of range");
   if (FAST_SIZE == 0)           $error("internal range must not be empty");

   logic [WIN_CNT*PAGE_W-1:0] pages;
   logic                      slow_speed;
   logic                      strobe, in_fast, cfg_hit, local_hit, cfg_we;
   logic                      vid_add;
   logic [WAIT_W-1:0]         waits;

   assign strobe    = cpu_rd || cpu_wr;
   assign in_fast   = (cpu_addr >= FAST_BASE) && (cpu_addr <= FAST_LAST);
   assign cfg_hit   = (cpu_addr[ADDR_W-1:IDX_W] == CFG_BASE[ADDR_W-1:IDX_W]);
   assign local_hit = in_fast || cfg_hit;
   assign cfg_we    = cpu_wr && cfg_hit && ready;

   if (VIDEO_WAITS) begin : g_video
      assign vid_add = video_hit;
   end else begin : g_no_video
      assign vid_add = 1'b0;
   end

   wm_page_file #(.WIN_CNT(WIN_CNT), .PAGE_W(PAGE_W)) u_pages (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cpu_addr[IDX_W-1:0]), .wr_data(cpu_wdata),
      .load_en(preset_load), .load_sel(preset_sel),
      .pages(pages), .slow_speed(slow_speed)
   );

   wm_xlate #(.ADDR_W(ADDR_W), .WIN_CNT(WIN_CNT), .PAGE_W(PAGE_W),
              .ROM_WIN(ROM_WIN), .ROM_PAGE(ROM_PAGE)) u_xlate (
      .addr(cpu_addr), .rom_en(rom_redirect), .pages(pages),
      .phys(mem_addr), .fast(mem_fast)
   );

   always_comb begin
      if (local_hit) waits = '0;
      else waits = WAIT_W'(!mem_fast) + WAIT_W'(slow_speed) + WAIT_W'(vid_add);
   end

   wm_wait_ctr u_wait (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .waits(waits), .ready(ready)
   );

   assign mem_sel = strobe && !local_hit;

   AST_ROM_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_redirect && cpu_addr[ADDR_W-1 -: IDX_W] == IDX_W'(ROM_WIN))
      |-> (mem_addr[PA_W-1 -: PAGE_W] == ROM_PAGE)); // R6

   AST_FAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && in_fast && ready) |=> ready); // R10

   AST_FAST_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      in_fast |-> !mem_sel); // R10

endmodule

// File: tb/win_mapper_tb.sv
module win_mapper_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic        video_hit = 1'b0, rom_redirect = 1'b0, preset_load = 1'b0;
   logic [2:0]  preset_sel = '0;
   logic        ready, mem_sel, mem_fast;
   logic [20:0] mem_addr;

   int n_checks = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   win_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .video_hit(video_hit),
      .rom_redirect(rom_redirect), .preset_load(preset_load),
      .preset_sel(preset_sel), .ready(ready), .mem_addr(mem_addr),
      .mem_sel(mem_sel), .mem_fast(mem_fast)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int mpg[8];
   int mspeed, mcnt;

   function automatic int ref_page(input logic [15:0] a, input bit rom);
      int w = int'(a) / 8192;
      if (rom && w == 2) return 'hBA;
      return mpg[w];
   endfunction

   function automatic bit ref_fast(input int p);
      return p >= 'hEC && p <= 'hEF;
   endfunction

   function automatic bit ref_local(input logic [15:0] a);
      return (a >= 16'hF000 && a <= 16'hF0FF) || (a >= 16'hF800 && a <= 16'hF807);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mpg = '{'hEC, 'hED, 'h07, 'h34, 'hEE, 'hEF, 'h03, 'h53};
         mspeed = 5; mcnt = 0;
      end else begin
         int p, w;
         bit ld;
         p  = ref_page(cpu_addr, rom_redirect);
         ld = preset_load && preset_sel >= 1 && preset_sel <= 5;
         if (mcnt > 0) mcnt--;
         else if (cpu_rd || cpu_wr) begin
            if (ref_local(cpu_addr)) w = 0;
            else w = (ref_fast(p) ? 0 : 1) + (mspeed == 1 ? 1 : 0) + (video_hit ? 1 : 0);
            if (cpu_wr && cpu_addr >= 16'hF800 && cpu_addr <= 16'hF807)
               mpg[cpu_addr[2:0]] = cpu_wdata;
            mcnt = w;
         end
         if (ld) begin
            mpg[0] = (preset_sel == 2 || preset_sel == 4) ? 'h33 : 'hEC;
            mpg[4] = (preset_sel >= 4) ? 'hEE : 'h34;
            mspeed = preset_sel;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int p;
         p = ref_page(cpu_addr, rom_redirect);
         chk(mem_addr == {p[7:0], cpu_addr[12:0]}, "R1 mem_addr", mem_addr, {p[7:0], cpu_addr[12:0]});
         chk(mem_fast == ref_fast(p), "R7 mem_fast", mem_fast, ref_fast(p));
         chk(mem_sel == ((cpu_rd || cpu_wr) && !ref_local(cpu_addr)), "R7 mem_sel",
             mem_sel, (cpu_rd || cpu_wr) && !ref_local(cpu_addr));
         chk(ready == (mcnt == 0), "R8 ready", ready, mcnt == 0);
      end
   end

   // ---------------- directed stimulus ----------------
   int got_waits, got_page;
   bit got_sel;

   task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] d, input bit vid);
      @(posedge clk); #1;
      cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d; video_hit = vid;
      @(negedge clk);
      got_sel  = mem_sel;
      got_page = int'(mem_addr[20:13]);
      @(posedge clk); #1;
      cpu_rd = 0; cpu_wr = 0; video_hit = 0;
      got_waits = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (ready) break;
         got_waits++;
      end
   endtask

   task automatic load_preset(input logic [2:0] s);
      @(posedge clk); #1;
      preset_load = 1; preset_sel = s;
      @(posedge clk); #1;
      preset_load = 0;
   endtask

   task automatic rd_expect(input logic [15:0] a, input bit vid, input int page,
                            input int waits, input string tag);
      access(a, 0, 8'h00, vid);
      chk(got_page == page, {tag, " page"}, got_page, page);
      chk(got_waits == waits, {tag, " waits"}, got_waits, waits);
   endtask

   initial begin
      int defaults[8] = '{'hEC, 'hED, 'h07, 'h34, 'hEE, 'hEF, 'h03, 'h53};
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(ready == 1'b1, "R2 ready after reset", ready, 1);
      chk(mem_sel == 1'b0, "R2 no select after reset", mem_sel, 0);

      // R2 / R8: defaults and page-class waits at preset 5
      for (int k = 0; k < 8; k++) begin
         rd_expect(16'(k * 'h2000 + 'h10), 0, defaults[k],
                   ref_fast(defaults[k]) ? 0 : 1, "R2");
         chk(got_sel == 1'b1, "R7 external select", got_sel, 1);
      end

      // R10: internal range bypass, boundary at F0FF / F100
      access(16'hF000, 0, 0, 0);
      chk(got_sel == 0 && got_waits == 0, "R10 F000 bypass", {got_sel, got_waits[3:0]}, 0);
      access(16'hF0FF, 0, 0, 0);
      chk(got_sel == 0 && got_waits == 0, "R10 F0FF bypass", {got_sel, got_waits[3:0]}, 0);
      rd_expect(16'hF100, 0, 'h53, 1, "R10 F100 mapped");

      // R3: configuration writes
      access(16'hF803, 1, 8'hEE, 0);
      chk(got_sel == 0 && got_waits == 0, "R3 config write quiet", {got_sel, got_waits[3:0]}, 0);
      rd_expect(16'h6000, 0, 'hEE, 0, "R3 window 3 rewritten");
      access(16'hF807, 1, 8'h12, 0);
      rd_expect(16'hE000, 0, 'h12, 1, "R3 window 7 rewritten");
      access(16'hF010, 0, 0, 0);
      chk(got_sel == 0 && got_waits == 0, "R10 bypass despite window 7", {got_sel, got_waits[3:0]}, 0);

      // R6: redirect of window 2
      rom_redirect = 1;
      rd_expect(16'h4000, 0, 'hBA, 1, "R6 redirect on");
      rom_redirect = 0;
      rd_expect(16'h4000, 0, 'h07, 1, "R6 redirect off");

      // R8: video wait on a fast page
      rd_expect(16'h0000, 1, 'hEC, 1, "R8 video wait");

      // R4 / R9: presets
      load_preset(3'd1);
      rd_expect(16'h0000, 0, 'hEC, 1, "R9 preset 1 fast page");
      rd_expect(16'h8000, 0, 'h34, 2, "R9 preset 1 slow page");
      rd_expect(16'h8000, 1, 'h34, 3, "R8 all three waits");
      load_preset(3'd2);
      rd_expect(16'h0000, 0, 'h33, 1, "R4 preset 2 window 0");
      load_preset(3'd4);
      rd_expect(16'h8000, 0, 'hEE, 0, "R4 preset 4 window 4");
      rd_expect(16'h0000, 0, 'h33, 1, "R4 preset 4 window 0");
      load_preset(3'd7);
      rd_expect(16'h0000, 0, 'h33, 1, "R4 code 7 ignored");
      load_preset(3'd0);
      rd_expect(16'h8000, 0, 'hEE, 0, "R4 code 0 ignored");

      // R5: preset beats a same-cycle config write to window 0
      @(posedge clk); #1;
      preset_load = 1; preset_sel = 3'd5;
      cpu_addr = 16'hF800; cpu_wr = 1; cpu_wdata = 8'h55;
      @(posedge clk); #1;
      preset_load = 0; cpu_wr = 0;
      rd_expect(16'h0000, 0, 'hEC, 0, "R5 preset wins");

      // R11: strobes during a wait are ignored
      load_preset(3'd1);
      @(posedge clk); #1;
      cpu_addr = 16'h8000; cpu_rd = 1; video_hit = 1;
      @(posedge clk); #1;
      cpu_rd = 0; video_hit = 0;
      cpu_addr = 16'hF800; cpu_wr = 1; cpu_wdata = 8'h77;
      got_waits = 0;
      @(negedge clk);
      if (!ready) got_waits++;
      @(posedge clk); #1;
      cpu_wr = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (ready) break;
         got_waits++;
      end
      chk(got_waits == 3, "R11 count not restarted", got_waits, 3);
      rd_expect(16'h0000, 0, 'hEC, 1, "R11 busy write dropped");

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule